// File: doc/BRIEF.md
# AC'97 output frame serializer

This block sits on the controller side of an AC'97 link and produces the outgoing serial frame. It runs on the link bit clock and drives two lines: the frame sync and the serial data line. The caller supplies a frame-valid flag, one valid flag for each of the twelve data slots, a register access (read/write flag, register index and write data), a left and a right PCM sample, and a mono flag. The block turns these into a 256-bit frame: a 16-bit tag slot followed by twelve 20-bit slots. Each slot is sent most significant bit first.

The block samples its inputs once, in the clock cycle that starts a frame. It holds that snapshot in a shift register while the frame goes out. A slot whose effective valid flag is clear is sent as all zeros, and so are the reserved and padding bits. Slots 5 to 12 have no data source here, so their payload is always zero. When the mono flag is set, the left sample is sent in both sample slots, and the right slot's tag bit follows the left slot's.

Both outputs change on the rising edge of the bit clock, so a codec can sample them on the falling edge. The next frame follows the previous one with no gap.

Top module: `aclink_out_framer`

## Requirements
- R1: While `rst_n` is low, `sync_o` and `sdata_o` are 0. The first rising clock edge after reset is released starts a frame, so `sync_o` is 1 from that edge onward.
- R2: A frame is 256 bit-clock periods long and frames follow one another without a gap. `sync_o` is 1 for the first 16 bit periods of a frame and 0 for the remaining 240.
- R3: The first 16 bits of a frame are the tag, sent MSB first. Tag bit 15 equals `frame_valid_i`. Tag bit 15-n carries the effective valid flag of slot n, for n = 1..12. Tag bits 2:0 are 0.
- R4: Slot 1 (frame bits 16..35) carries the read/write flag in bit 19 (1 = read, 0 = write) and the 7-bit register index in bits 18:12. Bits 11:0 are always 0.
- R5: Slot 2 (frame bits 36..55) carries the 16-bit register data in bits 19:4. Bits 3:0 are 0.
- R6: Slot 3 (frame bits 56..75) carries the left sample and slot 4 (frame bits 76..95) carries the right sample, each 20 bits wide and sent MSB first.
- R7: Every bit of a slot whose effective valid flag is 0 is sent as 0. Slots 5 to 12 always send 0 in all of their bits.
- R8: When `mono_i` is 1, slot 4 carries the left sample and slot 4's effective valid flag equals `slot_valid_i[2]`, which is slot 3's flag. The value of `pcm_right_i` and of `slot_valid_i[3]` then has no effect.
- R9: The inputs are sampled only in the cycle that starts a frame. A change to any input during a frame does not affect that frame, and it takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Link bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid_i | input | 1 | Value sent in tag bit 15 |
| slot_valid_i | input | 12 | Valid flag per slot; bit n-1 belongs to slot n |
| mono_i | input | 1 | Send the left sample in both sample slots |
| cmd_read_i | input | 1 | Register access direction, 1 = read |
| cmd_index_i | input | 7 | Register index sent in slot 1 |
| cmd_data_i | input | 16 | Register write data sent in slot 2 |
| pcm_left_i | input | 20 | Left PCM sample (slot 3) |
| pcm_right_i | input | 20 | Right PCM sample (slot 4) |
| sync_o | output | 1 | Frame sync, high during the tag slot |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
The bench aims at the framing boundaries. A design that starts its count one cycle late after reset puts a dead period before the first frame. A design that miscounts the wrap stretches or shortens frames, so the sync pulse drifts away from 16-in-256.

Register values with all ones and alternating bits catch a design that leaks index or data bits into the reserved field, or that packs slot 2 without its four-bit pad. A frame with every flag cleared, and one with only the unsourced slots flagged, catch a design that sends stale data in invalid slots. In mono mode, a different right sample and a cleared right flag expose a design that forgets to copy the sample or the tag bit.

In one test the inputs change halfway through a frame, which catches a design that reads its inputs live instead of from a snapshot. In another, reset is asserted while the sync pulse is high, to confirm that both lines drop at once.

// File: rtl/aclo_pkg.sv
package aclo_pkg;

   // slot numbers whose payload has a source inside the block
   localparam int SLOT_CMD   = 1;
   localparam int SLOT_DATA  = 2;
   localparam int SLOT_LEFT  = 3;
   localparam int SLOT_RIGHT = 4;

   function automatic int frame_len(input int tag_bits, input int slot_bits, input int num_slots);
      return tag_bits + slot_bits * num_slots;
   endfunction

endpackage

// File: rtl/aclo_bit_counter.sv
module aclo_bit_counter #(
   parameter int FRAME_BITS = 256,
   parameter int TAG_BITS   = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic wrap_o,
   output logic sync_o
);

   localparam int CW = $clog2(FRAME_BITS);
   localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
   localparam logic [CW-1:0] TAG_END  = CW'(TAG_BITS);

   logic [CW-1:0] pos_q;
   logic [CW-1:0] pos_next;

   assign wrap_o   = (pos_q == LAST_POS);
   assign pos_next = wrap_o ? '0 : pos_q + 1'b1;

   // reset parks on the last position so the first edge opens a frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= LAST_POS;
         sync_o <= 1'b0;
      end else begin
         pos_q  <= pos_next;
         sync_o <= (pos_next < TAG_END);
      end
   end

endmodule

// File: rtl/aclo_frame_build.sv
module aclo_frame_build
   import aclo_pkg::*;
#(
   parameter int TAG_BITS   = 16,
   parameter int SLOT_BITS  = 20,
   parameter int NUM_SLOTS  = 12,
   parameter int IDX_BITS   = 7,
   parameter int DATA_BITS  = 16,
   parameter int PCM_BITS   = 20,
   parameter int FRAME_BITS = frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS)
) (
   input  logic                  frame_valid_i,
   input  logic [NUM_SLOTS-1:0]  slot_valid_i,
   input  logic                  mono_i,
   input  logic                  cmd_read_i,
   input  logic [IDX_BITS-1:0]   cmd_index_i,
   input  logic [DATA_BITS-1:0]  cmd_data_i,
   input  logic [PCM_BITS-1:0]   pcm_left_i,
   input  logic [PCM_BITS-1:0]   pcm_right_i,
   output logic [FRAME_BITS-1:0] frame_o
);

   localparam int CMD_PAD  = SLOT_BITS - 1 - IDX_BITS;
   localparam int DATA_PAD = SLOT_BITS - DATA_BITS;
   localparam int PCM_PAD  = SLOT_BITS - PCM_BITS;

   logic [NUM_SLOTS:1]   eff_valid;
   logic [TAG_BITS-1:0]  tag;
   logic [SLOT_BITS-1:0] left_w;
   logic [SLOT_BITS-1:0] right_w;

   // mono: the right slot mirrors the left slot's flag
   always_comb begin
      for (int s = 1; s <= NUM_SLOTS; s++) begin
         eff_valid[s] = slot_valid_i[s-1];
      end
      if (mono_i) begin
         eff_valid[SLOT_RIGHT] = slot_valid_i[SLOT_LEFT-1];
      end
   end

   always_comb begin
      tag = '0;
      tag[TAG_BITS-1] = frame_valid_i;
      for (int s = 1; s <= NUM_SLOTS; s++) begin
         tag[TAG_BITS-1-s] = eff_valid[s];
      end
   end

   // sample width variant: full slot or left-justified with zero pad
   if (PCM_PAD == 0) begin : g_pcm_full
      assign left_w  = SLOT_BITS'(pcm_left_i);
      assign right_w = SLOT_BITS'(pcm_right_i);
   end else begin : g_pcm_pad
      assign left_w  = SLOT_BITS'(pcm_left_i)  << PCM_PAD;
      assign right_w = SLOT_BITS'(pcm_right_i) << PCM_PAD;
   end

   assign frame_o[FRAME_BITS-1 -: TAG_BITS] = tag;

   for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
      localparam int MSB_POS = FRAME_BITS - 1 - TAG_BITS - (s - 1) * SLOT_BITS;
      logic [SLOT_BITS-1:0] raw;
      if (s == SLOT_CMD) begin : g_cmd
         assign raw = SLOT_BITS'({cmd_read_i, cmd_index_i}) << CMD_PAD;
      end else if (s == SLOT_DATA) begin : g_data
         assign raw = SLOT_BITS'(cmd_data_i) << DATA_PAD;
      end else if (s == SLOT_LEFT) begin : g_left
         assign raw = left_w;
      end else if (s == SLOT_RIGHT) begin : g_right
         assign raw = mono_i ? left_w : right_w;
      end else begin : g_none
         assign raw = '0;
      end
      assign frame_o[MSB_POS -: SLOT_BITS] = eff_valid[s] ? raw : '0;
   end

endmodule

// File: rtl/aclo_shifter.sv
module aclo_shifter #(
   parameter int FRAME_BITS = 256
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  sdata_o
);

   logic [FRAME_BITS-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         sdata_o <= 1'b0;
      end else if (load_i) begin
         sdata_o <= frame_i[FRAME_BITS-1];
         hold_q  <= {frame_i[FRAME_BITS-2:0], 1'b0};
      end else begin
         sdata_o <= hold_q[FRAME_BITS-1];
         hold_q  <= {hold_q[FRAME_BITS-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer
   import aclo_pkg::*;
#(
   parameter int TAG_BITS  = 16,
   parameter int SLOT_BITS = 20,
   parameter int NUM_SLOTS = 12,
   parameter int IDX_BITS  = 7,
   parameter int DATA_BITS = 16,
   parameter int PCM_BITS  = 20
) (
   input  logic                 clk_bit,
   input  logic                 rst_n,
   input  logic                 frame_valid_i,
   input  logic [NUM_SLOTS-1:0] slot_valid_i,
   input  logic                 mono_i,
   input  logic                 cmd_read_i,
   input  logic [IDX_BITS-1:0]  cmd_index_i,
   input  logic [DATA_BITS-1:0] cmd_data_i,
   input  logic [PCM_BITS-1:0]  pcm_left_i,
   input  logic [PCM_BITS-1:0]  pcm_right_i,
   output logic                 sync_o,
   output logic                 sdata_o
);

   localparam int FRAME_BITS = frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS);

   if (NUM_SLOTS < SLOT_RIGHT) begin : g_bad_slots
      $error("NUM_SLOTS must cover both sample slots");
   end
   if (TAG_BITS < NUM_SLOTS + 1) begin : g_bad_tag
      $error("TAG_BITS too small for frame flag plus slot flags");
   end
   if (IDX_BITS + 1 > SLOT_BITS) begin : g_bad_idx
      $error("command field wider than a slot");
   end
   if (DATA_BITS > SLOT_BITS) begin : g_bad_data
      $error("DATA_BITS wider than a slot");
   end
   if (PCM_BITS > SLOT_BITS) begin : g_bad_pcm
      $error("PCM_BITS wider than a slot");
   end

   logic                  wrap;
   logic [FRAME_BITS-1:0] frame;

   aclo_bit_counter #(
      .FRAME_BITS (FRAME_BITS),
      .TAG_BITS   (TAG_BITS)
   ) u_cnt (
      .clk    (clk_bit),
      .rst_n  (rst_n),
      .wrap_o (wrap),
      .sync_o (sync_o)
   );

   aclo_frame_build #(
      .TAG_BITS   (TAG_BITS),
      .SLOT_BITS  (SLOT_BITS),
      .NUM_SLOTS  (NUM_SLOTS),
      .IDX_BITS   (IDX_BITS),
      .DATA_BITS  (DATA_BITS),
      .PCM_BITS   (PCM_BITS),
      .FRAME_BITS (FRAME_BITS)
   ) u_build (
      .frame_valid_i (frame_valid_i),
      .slot_valid_i  (slot_valid_i),
      .mono_i        (mono_i),
      .cmd_read_i    (cmd_read_i),
      .cmd_index_i   (cmd_index_i),
      .cmd_data_i    (cmd_data_i),
      .pcm_left_i    (pcm_left_i),
      .pcm_right_i   (pcm_right_i),
      .frame_o       (frame)
   );

   aclo_shifter #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk     (clk_bit),
      .rst_n   (rst_n),
      .load_i  (wrap),
      .frame_i (frame),
      .sdata_o (sdata_o)
   );

endmodule

// File: rtl/aclink_out_framer_chk.sv
module aclink_out_framer_chk #(
   parameter int TAG_BITS  = 16,
   parameter int SLOT_BITS = 20,
   parameter int NUM_SLOTS = 12,
   parameter int IDX_BITS  = 7,
   parameter int DATA_BITS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic sync,
   input logic sd
);

   localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * NUM_SLOTS;
   localparam int SW = $clog2(FRAME_BITS) + 1;

   logic                prev_q;
   logic                seen_q;
   logic [SW-1:0]       since_q;
   logic [TAG_BITS-1:0] tag_q;
   logic                rose;
   logic                tag_zero;
   logic                stuff_zero;
   logic                rsv_zero;

   assign rose = sync && !prev_q;

   // watches only the serial lines: bit index is rebuilt from the sync edge
   always_comb begin
      int b;
      int s;
      int off;
      b = int'(since_q) + 1;
      s = 0;
      off = 0;
      tag_zero   = 1'b0;
      stuff_zero = 1'b0;
      rsv_zero   = 1'b0;
      if (seen_q && !rose) begin
         if (b >= NUM_SLOTS + 1 && b < TAG_BITS) tag_zero = 1'b1;
         if (b >= TAG_BITS && b < FRAME_BITS) begin
            s   = (b - TAG_BITS) / SLOT_BITS + 1;
            off = (b - TAG_BITS) % SLOT_BITS;
            if (!tag_q[TAG_BITS-1-s]) stuff_zero = 1'b1;
            if (s == 1 && off >= 1 + IDX_BITS) rsv_zero = 1'b1;
            if (s == 2 && off >= DATA_BITS) rsv_zero = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         seen_q  <= 1'b0;
         since_q <= '0;
         tag_q   <= '0;
      end else begin
         prev_q <= sync;
         if (rose) begin
            seen_q  <= 1'b1;
            since_q <= '0;
            tag_q   <= {{(TAG_BITS-1){1'b0}}, sd};
         end else begin
            if (since_q != {SW{1'b1}}) since_q <= since_q + 1'b1;
            if (seen_q && int'(since_q) + 1 < TAG_BITS) tag_q <= {tag_q[TAG_BITS-2:0], sd};
         end
      end
   end

   a_r2_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
      (rose && seen_q) |-> (int'(since_q) == FRAME_BITS - 1));

   a_r2_sync_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && prev_q) |-> (int'(since_q) < TAG_BITS - 1));

   a_r2_sync_low: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !sync) |-> (int'(since_q) >= TAG_BITS - 1));

   a_r3_tag_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tag_zero |-> !sd);

   a_r7_invalid_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_zero |-> !sd);

   // R4 and R5: reserved tail of slot 1 and pad of slot 2
   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_zero |-> !sd);

endmodule

bind aclink_out_framer aclink_out_framer_chk #(
   .TAG_BITS  (TAG_BITS),
   .SLOT_BITS (SLOT_BITS),
   .NUM_SLOTS (NUM_SLOTS),
   .IDX_BITS  (IDX_BITS),
   .DATA_BITS (DATA_BITS)
) u_chk (
   .clk   (clk_bit),
   .rst_n (rst_n),
   .sync  (sync_o),
   .sd    (sdata_o)
);

// File: tb/sim_aclink_out_framer.sv
`timescale 1ns/1ps
module sim_aclink_out_framer;

   typedef struct packed {
      logic        fv;
      logic [11:0] sv;
      logic        mono;
      logic        rd;
      logic [6:0]  idx;
      logic [15:0] data;
      logic [19:0] left;
      logic [19:0] right;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 12'hFFF, 1'b0, 1'b0, 7'h02, 16'hA5C3, 20'h12345, 20'hABCDE},
      '{1'b1, 12'h00C, 1'b0, 1'b1, 7'h7F, 16'hFFFF, 20'hFFFFF, 20'h00001},
      '{1'b1, 12'h004, 1'b1, 1'b0, 7'h11, 16'h0000, 20'h80001, 20'h3C3C3},
      '{1'b0, 12'h000, 1'b0, 1'b1, 7'h55, 16'h1234, 20'h55555, 20'hAAAAA},
      '{1'b1, 12'h001, 1'b0, 1'b1, 7'h55, 16'hFFFF, 20'h0F0F0, 20'hF0F0F},
      '{1'b1, 12'hFF0, 1'b1, 1'b1, 7'h2A, 16'h5A5A, 20'hFFFFF, 20'hFFFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_valid;
   logic [11:0] slot_valid;
   logic        mono;
   logic        cmd_read;
   logic [6:0]  cmd_index;
   logic [15:0] cmd_data;
   logic [19:0] pcm_left;
   logic [19:0] pcm_right;
   logic        sync_o;
   logic        sdata_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic last_sync = 1'b0;

   always #2.5 clk = ~clk;

   aclink_out_framer u0 (
      .clk_bit       (clk),
      .rst_n         (rst_n),
      .frame_valid_i (frame_valid),
      .slot_valid_i  (slot_valid),
      .mono_i        (mono),
      .cmd_read_i    (cmd_read),
      .cmd_index_i   (cmd_index),
      .cmd_data_i    (cmd_data),
      .pcm_left_i    (pcm_left),
      .pcm_right_i   (pcm_right),
      .sync_o        (sync_o),
      .sdata_o       (sdata_o)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      frame_valid = v.fv;
      slot_valid  = v.sv;
      mono        = v.mono;
      cmd_read    = v.rd;
      cmd_index   = v.idx;
      cmd_data    = v.data;
      pcm_left    = v.left;
      pcm_right   = v.right;
   endtask

   // expected frame from the requirements; bit 255 goes out first
   function automatic logic [255:0] exp_frame(input vec_t v);
      logic [255:0] f;
      logic [11:0]  ev;
      f  = '0;
      ev = v.sv;
      if (v.mono) ev[3] = v.sv[2];
      f[255] = v.fv;
      for (int s = 1; s <= 12; s++) f[255-s] = ev[s-1];
      if (ev[0]) f[239 -: 20] = {v.rd, v.idx, 12'h000};
      if (ev[1]) f[219 -: 20] = {v.data, 4'h0};
      if (ev[2]) f[199 -: 20] = v.left;
      if (ev[3]) f[179 -: 20] = v.mono ? v.left : v.right;
      return f;
   endfunction

   // waits for the sync rise, then records 256 bits at falling edges
   task automatic capture(output logic [255:0] got, output int waited);
      int bad_sync;
      waited = 0;
      bad_sync = 0;
      forever begin
         @(negedge clk);
         waited++;
         if (sync_o && !last_sync) break;
         last_sync = sync_o;
         if (waited > 600) break;
      end
      got[255] = sdata_o;
      last_sync = sync_o;
      for (int k = 1; k < 256; k++) begin
         @(negedge clk);
         got[255-k] = sdata_o;
         if (sync_o !== (k < 16)) bad_sync++;
         last_sync = sync_o;
      end
      chk("R2", "sync high 16 of 256 bits, mismatches", 64'(bad_sync), 64'd0);
   endtask

   task automatic compare(input vec_t v, input logic [255:0] got, input string tagname);
      logic [255:0] e;
      e = exp_frame(v);
      chk("R3", {tagname, " tag"}, 64'(got[255:240]), 64'(e[255:240]));
      chk(e[239] || e[238:220] != 0 || v.sv[0] ? "R4" : "R7", {tagname, " slot1"},
          64'(got[239:220]), 64'(e[239:220]));
      chk(v.sv[1] ? "R5" : "R7", {tagname, " slot2"}, 64'(got[219:200]), 64'(e[219:200]));
      chk(v.sv[2] ? "R6" : "R7", {tagname, " slot3"}, 64'(got[199:180]), 64'(e[199:180]));
      chk(v.mono ? "R8" : "R6", {tagname, " slot4"}, 64'(got[179:160]), 64'(e[179:160]));
      chk("R7", {tagname, " slots5-12 any bit set"}, 64'(|got[159:0]), 64'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [255:0] got;
      int waited;
      rst_n = 1'b0;
      apply(VECS[0]);
      repeat (3) @(negedge clk);
      chk("R1", "sync in reset", 64'(sync_o), 64'd0);
      chk("R1", "sdata in reset", 64'(sdata_o), 64'd0);
      rst_n = 1'b1;
      last_sync = 1'b0;
      capture(got, waited);
      chk("R1", "falling edges to first frame", 64'(waited), 64'd1);
      compare(VECS[0], got, "first frame");

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         capture(got, waited);
         chk("R2", "gap between frames", 64'(waited), 64'd1);
         compare(VECS[i], got, $sformatf("vector %0d", i));
      end

      // R9: inputs change in the middle of a frame
      apply(VECS[0]);
      fork
         capture(got, waited);
         begin
            repeat (30) @(negedge clk);
            apply(VECS[1]);
         end
      join
      compare(VECS[0], got, "R9 frame with mid-frame change");
      capture(got, waited);
      compare(VECS[1], got, "R9 following frame");

      // R8: right input and its flag have no effect in mono
      apply('{1'b1, 12'h004, 1'b1, 1'b0, 7'h00, 16'h0000, 20'h6B6B6, 20'h00000});
      capture(got, waited);
      chk("R8", "mono slot4 equals left", 64'(got[179:160]), 64'h6B6B6);
      chk("R8", "mono slot4 tag copies slot3", 64'(got[251]), 64'd1);

      // R1: reset while sync is high
      apply(VECS[0]);
      capture(got, waited);
      @(negedge clk);
      chk("R1", "sync before mid-frame reset", 64'(sync_o), 64'd1);
      rst_n = 1'b0;
      #1;
      chk("R1", "sync drops on reset", 64'(sync_o), 64'd0);
      chk("R1", "sdata drops on reset", 64'(sdata_o), 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      last_sync = 1'b0;
      capture(got, waited);
      chk("R1", "restart after reset", 64'(waited), 64'd1);
      compare(VECS[0], got, "after reset");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule